// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Unit

This unit executes the reservation-based pair of atomic instructions for a RISC-V style integer pipeline. The pipeline hands it a raw instruction word together with the base register value and the store data. The unit decodes and checks the word. It runs at most one memory access through a single-outstanding memory port. When it finishes, it returns one result: a destination register value, a retire flag, or an exception with its cause code.

The unit holds a single reservation, made of a valid flag and a physical address. A load-reserved that completes sets the reservation. A store-conditional compares its address with the reservation at 8-byte granule resolution, then clears the reservation, whatever the outcome. Addresses are already physical. Acquire/release bits pass straight through to the memory port. An external kill input drops the reservation when another agent writes the reserved location.

All three data interfaces use valid/ready. `req_ready` is high only while the unit is idle, so a new request waits until the previous result has been taken. A memory request holds its valid and all its fields stable until `mem_req_ready` is seen. The memory returns exactly one `mem_rsp_valid` pulse per accepted request, and there is no back-pressure on responses. A result holds its valid and all its fields until `res_ready` is seen.

Top module: `lrsc_unit`

## Requirements
- R1: A word is legal only with opcode bits[6:0]=0101111, bit14=0, and bits[31:27] equal to 00010 (load-reserved) or 00011 (store-conditional). A load-reserved also needs bits[24:20]=00000. An illegal word returns exception cause 2, with no retire, no rd write and no memory request.
- R2: The size field bits[13:12] selects width: 10 is word, and 11 is doubleword, legal only when XLEN>=64. Sizes 00 and 01 are illegal with cause 2.
- R3: The effective address is the rs1 value with no offset. A misaligned load-reserved returns cause 4 and a misaligned store-conditional returns cause 6. Neither issues a memory request nor changes the reservation.
- R4: A load-reserved issues one read with the address, the size field and the aq (bit 26) and rl (bit 25) bits. On a good response it retires, writes rd (bits[11:7]) with the loaded value sign-extended from the access width, and sets the reservation.
- R5: A store-conditional without a matching valid reservation issues no write, retires, and writes rd with 1.
- R6: A store-conditional that matches issues one write carrying the low width bytes of rs2, with the upper bits zero. rd gets 0 when the response reports write success and 1 when it reports failure.
- R7: Every store-conditional that passes decode and alignment clears the reservation, whether or not it hits.
- R8: A response error raises cause 5 for a load-reserved and cause 7 for a store-conditional, with no retire and no rd write.
- R9: A reservation matches any address in the same naturally aligned 8-byte granule.
- R10: Reset clears the reservation. A pulse on `resv_kill` clears it, and the kill wins over a load-reserved completing in the same cycle.
- R11: `req_ready` is high only when idle. The memory request and the result each hold valid and data stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request accepted |
| req_insn | input | 32 | Instruction word |
| req_rs1_val | input | XLEN | Base address value |
| req_rs2_val | input | XLEN | Store data value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | XLEN | Physical address |
| mem_req_wdata | output | XLEN | Write data, right-aligned |
| mem_req_size | output | 2 | Size code (10 word, 11 doubleword) |
| mem_req_aq | output | 1 | Acquire bit |
| mem_req_rl | output | 1 | Release bit |
| mem_rsp_valid | input | 1 | Response pulse |
| mem_rsp_rdata | input | XLEN | Read data, right-aligned |
| mem_rsp_err | input | 1 | Access fault |
| mem_rsp_wok | input | 1 | Conditional write performed |
| resv_kill | input | 1 | External reservation invalidate |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Pipeline takes result |
| res_retire | output | 1 | Instruction retires |
| res_exc | output | 1 | Exception raised |
| res_cause | output | 5 | Exception cause code |
| res_rd_we | output | 1 | Write rd |
| res_rd_idx | output | 5 | rd index |
| res_rd_val | output | XLEN | rd value |

## Verification
Assertions check the handshake rules on every cycle: the memory request and the result stay stable under back-pressure, and the unit is busy whenever a memory request or a result is pending. They also check that a kill or a store-conditional check empties the reservation one cycle later, that a write is never in flight while a reservation is held, and that an exception never comes with a retire or an rd write. Only the bench scenarios can show the data results. These are the decode and alignment causes, the sign extension, the granule match, the 0/1 store-conditional codes, and the kill winning a same-cycle race, all checked against a reference reservation kept in the bench.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
  localparam logic [4:0] F5_LR      = 5'b00010;
  localparam logic [4:0] F5_SC      = 5'b00011;
  localparam logic [1:0] SZ_WORD    = 2'b10;
  localparam logic [1:0] SZ_DWORD   = 2'b11;

  localparam logic [4:0] CAUSE_ILLEGAL   = 5'd2;
  localparam logic [4:0] CAUSE_LD_MISAL  = 5'd4;
  localparam logic [4:0] CAUSE_LD_FAULT  = 5'd5;
  localparam logic [4:0] CAUSE_ST_MISAL  = 5'd6;
  localparam logic [4:0] CAUSE_ST_FAULT  = 5'd7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MREQ,
    ST_MWAIT,
    ST_DONE
  } lrsc_state_e;

  typedef struct packed {
    logic       is_sc;
    logic       illegal;
    logic       misal;
    logic       aq;
    logic       rl;
    logic [1:0] size;
    logic [4:0] rd;
  } lrsc_dec_t;
endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] addr,
  output lrsc_dec_t       dec
);
  localparam bit DW_OK = (XLEN >= 64);

  logic [4:0] f5;
  logic [1:0] sz;
  logic       fmt_ok, width_ok, rs2_ok;

  always_comb begin
    f5       = insn[31:27];
    sz       = insn[13:12];
    fmt_ok   = (insn[6:0] == OPC_ATOMIC) && !insn[14] &&
               ((f5 == F5_LR) || (f5 == F5_SC));
    width_ok = (sz == SZ_WORD) || ((sz == SZ_DWORD) && DW_OK);
    rs2_ok   = (f5 != F5_LR) || (insn[24:20] == 5'd0);
    dec.is_sc   = (f5 == F5_SC);
    dec.illegal = !(fmt_ok && width_ok && rs2_ok);
    dec.misal   = (sz == SZ_DWORD) ? (addr[2:0] != 3'd0) : (addr[1:0] != 2'd0);
    dec.aq      = insn[26];
    dec.rl      = insn[25];
    dec.size    = sz;
    dec.rd      = insn[11:7];
  end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int XLEN    = 64,
  parameter int GRAN_LG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic [XLEN-1:0] set_addr,
  input  logic            clear,
  input  logic            kill,
  input  logic [XLEN-1:0] chk_addr,
  output logic            hit,
  output logic            valid
);
  localparam int TAG_W = XLEN - GRAN_LG;

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      if (kill || clear) valid_q <= 1'b0;
      else if (set)      valid_q <= 1'b1;
      if (set) tag_q <= set_addr[XLEN-1:GRAN_LG];
    end
  end

  assign hit   = valid_q && (tag_q == chk_addr[XLEN-1:GRAN_LG]);
  assign valid = valid_q;

  // R10
  kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !valid_q);
  // R7
  check_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !valid_q);
endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  lrsc_dec_t       dec,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic            resv_hit,
  output logic            resv_set,
  output logic [XLEN-1:0] resv_set_addr,
  output logic            resv_clear,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  output logic [1:0]      mem_req_size,
  output logic            mem_req_aq,
  output logic            mem_req_rl,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_rdata,
  input  logic            mem_rsp_err,
  input  logic            mem_rsp_wok,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            res_retire,
  output logic            res_exc,
  output logic [4:0]      res_cause,
  output logic            res_rd_we,
  output logic [4:0]      res_rd_idx,
  output logic [XLEN-1:0] res_rd_val
);
  lrsc_state_e     st_q;
  logic            sc_q, aq_q, rl_q;
  logic [1:0]      size_q;
  logic [XLEN-1:0] addr_q, wdata_q;
  logic            r_retire_q, r_exc_q, r_we_q;
  logic [4:0]      r_cause_q, rd_q;
  logic [XLEN-1:0] r_val_q;
  logic            accept, rsp_in, checks;
  logic [XLEN-1:0] load_ext, store_trim;

  assign accept = (st_q == ST_IDLE) && req_valid;
  assign rsp_in = (st_q == ST_MWAIT) && mem_rsp_valid;
  assign checks = accept && !dec.illegal && !dec.misal && dec.is_sc;

  always_comb begin
    if (size_q == SZ_DWORD) load_ext = mem_rsp_rdata;
    else                    load_ext = XLEN'(signed'(mem_rsp_rdata[31:0]));
    if (dec.size == SZ_DWORD) store_trim = rs2_val;
    else                      store_trim = XLEN'(rs2_val[31:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sc_q       <= 1'b0;
      aq_q       <= 1'b0;
      rl_q       <= 1'b0;
      size_q     <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rd_q       <= '0;
      r_retire_q <= 1'b0;
      r_exc_q    <= 1'b0;
      r_we_q     <= 1'b0;
      r_cause_q  <= '0;
      r_val_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          sc_q    <= dec.is_sc;
          aq_q    <= dec.aq;
          rl_q    <= dec.rl;
          size_q  <= dec.size;
          addr_q  <= rs1_val;
          wdata_q <= store_trim;
          rd_q    <= dec.rd;
          r_val_q <= '0;
          if (dec.illegal || dec.misal) begin
            r_retire_q <= 1'b0;
            r_exc_q    <= 1'b1;
            r_we_q     <= 1'b0;
            r_cause_q  <= dec.illegal ? CAUSE_ILLEGAL :
                          (dec.is_sc ? CAUSE_ST_MISAL : CAUSE_LD_MISAL);
            st_q       <= ST_DONE;
          end else if (dec.is_sc && !resv_hit) begin
            r_retire_q <= 1'b1;
            r_exc_q    <= 1'b0;
            r_we_q     <= 1'b1;
            r_cause_q  <= '0;
            r_val_q    <= XLEN'(1);
            st_q       <= ST_DONE;
          end else begin
            st_q <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) st_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          st_q <= ST_DONE;
          if (mem_rsp_err) begin
            r_retire_q <= 1'b0;
            r_exc_q    <= 1'b1;
            r_we_q     <= 1'b0;
            r_cause_q  <= sc_q ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
          end else begin
            r_retire_q <= 1'b1;
            r_exc_q    <= 1'b0;
            r_we_q     <= 1'b1;
            r_cause_q  <= '0;
            r_val_q    <= sc_q ? XLEN'(!mem_rsp_wok) : load_ext;
          end
        end
        ST_DONE: if (res_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign resv_clear    = checks;
  assign resv_set      = rsp_in && !sc_q && !mem_rsp_err;
  assign resv_set_addr = addr_q;

  assign mem_req_valid = (st_q == ST_MREQ);
  assign mem_req_we    = sc_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = sc_q ? wdata_q : '0;
  assign mem_req_size  = size_q;
  assign mem_req_aq    = aq_q;
  assign mem_req_rl    = rl_q;

  assign res_valid  = (st_q == ST_DONE);
  assign res_retire = r_retire_q;
  assign res_exc    = r_exc_q;
  assign res_cause  = r_cause_q;
  assign res_rd_we  = r_we_q;
  assign res_rd_idx = rd_q;
  assign res_rd_val = r_val_q;

  // R11
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_we) && $stable(mem_req_wdata) && $stable(mem_req_size));
  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_rd_val) &&
      $stable(res_exc) && $stable(res_cause) && $stable(res_rd_we));
  // R8
  exc_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_exc |-> !res_rd_we && !res_retire);
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
  import lrsc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int GRAN_LG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_insn,
  input  logic [XLEN-1:0] req_rs1_val,
  input  logic [XLEN-1:0] req_rs2_val,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  output logic [1:0]      mem_req_size,
  output logic            mem_req_aq,
  output logic            mem_req_rl,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_rdata,
  input  logic            mem_rsp_err,
  input  logic            mem_rsp_wok,
  input  logic            resv_kill,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            res_retire,
  output logic            res_exc,
  output logic [4:0]      res_cause,
  output logic            res_rd_we,
  output logic [4:0]      res_rd_idx,
  output logic [XLEN-1:0] res_rd_val
);
  lrsc_dec_t       dec;
  logic            hit, rv_valid, rv_set, rv_clear;
  logic [XLEN-1:0] rv_set_addr;

  lrsc_decode #(.XLEN(XLEN)) u_dec (
    .insn (req_insn),
    .addr (req_rs1_val),
    .dec  (dec)
  );

  lrsc_resv #(.XLEN(XLEN), .GRAN_LG(GRAN_LG)) u_resv (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (rv_set),
    .set_addr (rv_set_addr),
    .clear    (rv_clear),
    .kill     (resv_kill),
    .chk_addr (req_rs1_val),
    .hit      (hit),
    .valid    (rv_valid)
  );

  lrsc_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .dec           (dec),
    .rs1_val       (req_rs1_val),
    .rs2_val       (req_rs2_val),
    .resv_hit      (hit),
    .resv_set      (rv_set),
    .resv_set_addr (rv_set_addr),
    .resv_clear    (rv_clear),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_size  (mem_req_size),
    .mem_req_aq    (mem_req_aq),
    .mem_req_rl    (mem_req_rl),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .mem_rsp_err   (mem_rsp_err),
    .mem_rsp_wok   (mem_rsp_wok),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_retire    (res_retire),
    .res_exc       (res_exc),
    .res_cause     (res_cause),
    .res_rd_we     (res_rd_we),
    .res_rd_idx    (res_rd_idx),
    .res_rd_val    (res_rd_val)
  );

  // R7
  no_write_with_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> !rv_valid);
  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || res_valid) |-> !req_ready);
endmodule

// File: tb/lrsc_unit_tb.sv
module lrsc_unit_tb_top;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_insn = '0;
  logic [XLEN-1:0] req_rs1_val = '0, req_rs2_val = '0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_we, mem_req_aq, mem_req_rl;
  logic [XLEN-1:0] mem_req_addr, mem_req_wdata;
  logic [1:0] mem_req_size;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0, mem_rsp_wok = 1'b0;
  logic [XLEN-1:0] mem_rsp_rdata = '0;
  logic resv_kill = 1'b0;
  logic res_valid, res_ready = 1'b0, res_retire, res_exc, res_rd_we;
  logic [4:0] res_cause, res_rd_idx;
  logic [XLEN-1:0] res_rd_val;

  int checks = 0;
  int errors = 0;
  bit ref_v = 1'b0;
  logic [XLEN-1:0] ref_a = '0;

  always #5 clk = ~clk;

  lrsc_unit #(.XLEN(XLEN)) dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] f5, input bit aq, input bit rl,
                                     input logic [4:0] rs2, input logic [1:0] sz,
                                     input logic [4:0] rd);
    return {f5, aq, rl, rs2, 5'd1, 1'b0, sz, rd, 7'b0101111};
  endfunction

  function automatic logic [XLEN-1:0] sext(input logic [XLEN-1:0] d, input logic [1:0] sz);
    if (sz == 2'b11) return d;
    return {{32{d[31]}}, d[31:0]};
  endfunction

  task automatic pulse_kill();
    @(negedge clk); resv_kill = 1'b1;
    @(negedge clk); resv_kill = 1'b0;
    ref_v = 1'b0;
  endtask

  task automatic do_op(input logic [31:0] insn, input logic [XLEN-1:0] a,
                       input logic [XLEN-1:0] d, input logic [XLEN-1:0] rdat,
                       input bit err, input bit wok, input bit kill_at_rsp);
    logic [4:0] f5; logic [1:0] sz;
    bit ill, mis, lr, hit, exp_mem, saw_mem, got_res;
    bit m_we, m_aq, m_rl; logic [XLEN-1:0] m_addr, m_wdata; logic [1:0] m_sz;
    bit e_exc; logic [4:0] e_cause; logic [XLEN-1:0] e_val, e_wd;
    f5 = insn[31:27]; sz = insn[13:12]; lr = (f5 == 5'b00010);
    // R1 R2: independent legality model
    ill = (insn[6:0] != 7'b0101111) || insn[14] || (f5 != 5'b00010 && f5 != 5'b00011) ||
          (sz != 2'b10 && sz != 2'b11) || (lr && insn[24:20] != 5'd0);
    mis = (sz == 2'b11) ? (a[2:0] != 0) : (a[1:0] != 0);
    hit = ref_v && (ref_a[XLEN-1:3] == a[XLEN-1:3]);
    exp_mem = !ill && !mis && (lr || hit);
    e_wd = (sz == 2'b11) ? d : {32'd0, d[31:0]};
    if (ill)                  begin e_exc = 1; e_cause = 5'd2; end
    else if (mis)             begin e_exc = 1; e_cause = lr ? 5'd4 : 5'd6; end
    else if (exp_mem && err)  begin e_exc = 1; e_cause = lr ? 5'd5 : 5'd7; end
    else                      begin e_exc = 0; e_cause = 5'd0; end
    e_val = lr ? sext(rdat, sz) : ((hit && !wok) || !hit ? 64'd1 : 64'd0);
    saw_mem = 0; got_res = 0;
    m_we = 0; m_aq = 0; m_rl = 0; m_addr = '0; m_wdata = '0; m_sz = '0;

    @(negedge clk);
    check(req_ready === 1'b1, "R11 idle ready", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_insn = insn; req_rs1_val = a; req_rs2_val = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 40 && !got_res; cyc++) begin
      if (mem_req_valid && !saw_mem) begin
        saw_mem = 1;
        check(req_ready === 1'b0, "R11 busy not ready", {63'd0, req_ready}, 64'd0);
        m_we = mem_req_we; m_aq = mem_req_aq; m_rl = mem_req_rl;
        m_addr = mem_req_addr; m_wdata = mem_req_wdata; m_sz = mem_req_size;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_rdata = rdat; mem_rsp_err = err; mem_rsp_wok = wok;
        resv_kill = kill_at_rsp;
        @(negedge clk);
        mem_rsp_valid = 1'b0; resv_kill = 1'b0;
      end else if (res_valid) begin
        got_res = 1;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        check(res_valid === 1'b1, "R11 result held", {63'd0, res_valid}, 64'd1);
        check(res_exc === e_exc && (e_exc ? res_cause === e_cause : 1'b1),
              "R1 R2 R3 R8 exception/cause", {58'd0, res_exc, res_cause}, {58'd0, e_exc, e_cause});
        check(res_retire === !e_exc && res_rd_we === !e_exc,
              "R8 retire/rd_we", {62'd0, res_retire, res_rd_we}, {62'd0, !e_exc, !e_exc});
        if (!e_exc) begin
          check(res_rd_val === e_val, lr ? "R4 LR rd value" : "R5 R6 SC rd code", res_rd_val, e_val);
          check(res_rd_idx === insn[11:7], "R4 rd index", {59'd0, res_rd_idx}, {59'd0, insn[11:7]});
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
      end else @(negedge clk);
    end
    if (!got_res) check(0, "watchdog", 64'd0, 64'd1);
    check(saw_mem == exp_mem, "R3 R5 memory request issued", {63'd0, saw_mem}, {63'd0, exp_mem});
    if (saw_mem && exp_mem) begin
      check(m_we == !lr && m_addr === a && m_sz === sz && m_aq == insn[26] && m_rl == insn[25],
            "R4 R6 request fields", m_addr, a);
      if (!lr) check(m_wdata === e_wd, "R6 write data", m_wdata, e_wd);
    end
    // R7 R10: reference reservation
    if (!ill && !mis && !lr) ref_v = 0;
    if (!ill && !mis && lr && !err) begin ref_v = !kill_at_rsp; ref_a = a; end
  endtask

  localparam logic [4:0] LR = 5'b00010, SC = 5'b00011;

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check(res_valid === 0 && mem_req_valid === 0, "R10 reset outputs idle",
          {62'd0, res_valid, mem_req_valid}, 64'd0);
    rst_n = 1'b1;
    // R10: no reservation after reset
    do_op(mk(SC, 0, 0, 5'd2, 2'b11, 5'd3), 64'h100, 64'h55, 0, 0, 1, 0);
    // R4 R9 R6: LR word negative data, SC same granule
    do_op(mk(LR, 1, 0, 5'd0, 2'b10, 5'd4), 64'h100, 0, 64'hDEAD_BEEF_8000_0001, 0, 1, 0);
    do_op(mk(SC, 0, 1, 5'd2, 2'b10, 5'd5), 64'h104, 64'hFFFF_0000_1234_5678, 0, 0, 1, 0);
    // R7: reservation gone after success
    do_op(mk(SC, 0, 0, 5'd2, 2'b10, 5'd5), 64'h100, 64'h1, 0, 0, 1, 0);
    // R9 R7: other granule misses and still clears
    do_op(mk(LR, 0, 0, 5'd0, 2'b11, 5'd6), 64'h200, 0, 64'h0123_4567_89AB_CDEF, 0, 1, 0);
    do_op(mk(SC, 0, 0, 5'd2, 2'b11, 5'd6), 64'h208, 64'h7, 0, 0, 1, 0);
    do_op(mk(SC, 0, 0, 5'd2, 2'b11, 5'd6), 64'h200, 64'h7, 0, 0, 1, 0);
    // R10: kill input
    do_op(mk(LR, 0, 0, 5'd0, 2'b10, 5'd7), 64'h300, 0, 64'h11, 0, 1, 0);
    pulse_kill();
    do_op(mk(SC, 0, 0, 5'd2, 2'b10, 5'd7), 64'h300, 64'h9, 0, 0, 1, 0);
    // R10: kill same cycle as LR completion wins
    do_op(mk(LR, 0, 0, 5'd0, 2'b10, 5'd7), 64'h300, 0, 64'h11, 0, 1, 1);
    do_op(mk(SC, 0, 0, 5'd2, 2'b10, 5'd7), 64'h300, 64'h9, 0, 0, 1, 0);
    // R3: misaligned both kinds, reservation kept
    do_op(mk(LR, 0, 0, 5'd0, 2'b10, 5'd8), 64'h400, 0, 64'h22, 0, 1, 0);
    do_op(mk(LR, 0, 0, 5'd0, 2'b10, 5'd8), 64'h402, 0, 64'h22, 0, 1, 0);
    do_op(mk(SC, 0, 0, 5'd2, 2'b11, 5'd8), 64'h404, 64'h3, 0, 0, 1, 0);
    // R6: write failure reported as 1
    do_op(mk(SC, 0, 0, 5'd2, 2'b10, 5'd8), 64'h400, 64'h3, 0, 0, 0, 0);
    // R1 R2: illegal encodings
    do_op(mk(LR, 0, 0, 5'd0, 2'b00, 5'd9), 64'h500, 0, 0, 0, 1, 0);
    do_op(mk(SC, 0, 0, 5'd2, 2'b01, 5'd9), 64'h500, 0, 0, 0, 1, 0);
    do_op(mk(LR, 0, 0, 5'd3, 2'b10, 5'd9), 64'h500, 0, 0, 0, 1, 0);
    do_op(mk(5'b00001, 0, 0, 5'd3, 2'b10, 5'd9), 64'h500, 0, 0, 0, 1, 0);
    do_op(mk(LR, 0, 0, 5'd0, 2'b10, 5'd9) ^ 32'h4000, 64'h500, 0, 0, 0, 1, 0);
    // R8: access faults
    do_op(mk(LR, 0, 0, 5'd0, 2'b11, 5'd10), 64'h600, 0, 64'h5, 1, 1, 0);
    do_op(mk(LR, 0, 0, 5'd0, 2'b11, 5'd10), 64'h600, 0, 64'h5, 0, 1, 0);
    do_op(mk(SC, 0, 0, 5'd2, 2'b11, 5'd10), 64'h600, 64'h5, 0, 1, 1, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] f5; logic [1:0] sz; logic [XLEN-1:0] a; logic [4:0] rs2;
      f5  = ($urandom_range(0, 15) == 0) ? 5'b00100 : ($urandom_range(0, 1) ? LR : SC);
      sz  = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(2, 3));
      rs2 = (f5 == LR && $urandom_range(0, 9) != 0) ? 5'd0 : 5'($urandom);
      a   = 64'h1000 + 64'($urandom_range(0, 3) * 8);
      if ($urandom_range(0, 7) != 0) a = (sz == 2'b11) ? a : a + 64'($urandom_range(0, 1) * 4);
      else a = a + 64'($urandom_range(1, 3));
      do_op(mk(f5, 1'($urandom), 1'($urandom), rs2, sz, 5'($urandom)), a,
            {$urandom, $urandom}, {$urandom, $urandom},
            $urandom_range(0, 15) == 0, $urandom_range(0, 7) != 0, $urandom_range(0, 19) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule